// File: doc/BRIEF.md
# Memory-Card Host Data FIFO with Interrupt Status

This block sits between the host bus and the card-side data engine of a memory-card host controller. It holds a 16-entry, 32-bit data FIFO. The host and the card side can each push and pop. Data leaves in first-in, first-out order through a registered read-data output, and the current fill level is visible as a count with full and empty flags. At most one side pushes and one side pops in any cycle. If both sides request the same operation, the host request is taken and the card request is ignored.

The card side is trusted by design: it never pushes into a full FIFO or pops from an empty one. Any such card request is simply dropped. Host misuse is flagged instead: a host push into a full FIFO, or a host pop from an empty FIFO, latches a FIFO error status bit and leaves the storage untouched. Alongside that bit the block latches a host starvation timeout, a shared read-timeout/boot-data-start bit, and a transfer-done bit. The meaning of the shared bit depends on a boot-mode input. Software clears each status bit by writing a one to it. A single level interrupt output is raised while any status bit that is enabled in an interrupt enable register is set.

Top module: `sdh_fifo_irq`

## Requirements
- R1: Accepted pushes are read back in push order. `rd_data` takes the popped word in the cycle after the accepted pop and holds it until the next accepted pop.
- R2: `fifo_count` gives the number of stored words (0 to 16). `fifo_full` is high exactly at 16 and `fifo_empty` is high exactly at 0.
- R3: A host push while the FIFO is full sets status bit 11 (FIFO error) on the next cycle and changes neither the count nor the stored words.
- R4: A host pop while the FIFO is empty sets status bit 11 on the next cycle. It leaves `rd_data` and the count unchanged, and the read position does not move.
- R5: A card push while full, or a card pop while empty, is ignored and never sets status bit 11.
- R6: A pulse on `starve_evt` sets status bit 10 (host starvation timeout).
- R7: With `boot_mode` low, a pulse on `rd_timeout_evt` sets both status bit 9 and status bit 3 (transfer done). A pulse on `xfer_done_evt` sets bit 3 on its own.
- R8: With `boot_mode` high, `boot_start_evt` sets status bit 9 and `rd_timeout_evt` has no effect. With `boot_mode` low, `boot_start_evt` has no effect.
- R9: A cycle with `stat_clr_wr` high clears every status bit whose `stat_clr_data` bit is 1 and leaves bits written as 0 unchanged.
- R10: When a set event and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R11: `irq` is high whenever any status bit is set whose bit in the interrupt enable register is 1. A write with `irq_en_wr` loads that register from `irq_en_data`. The enable register never alters the status bits.
- R12: After reset the FIFO is empty, `rd_data` is 0, all status bits are 0, the enable register is 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_push | input | 1 | Host push request |
| host_wdata | input | 32 | Host push data |
| host_pop | input | 1 | Host pop request |
| card_push | input | 1 | Card-side push request |
| card_wdata | input | 32 | Card-side push data |
| card_pop | input | 1 | Card-side pop request |
| rd_data | output | 32 | Last popped word (registered) |
| fifo_count | output | 5 | Number of stored words |
| fifo_full | output | 1 | FIFO holds 16 words |
| fifo_empty | output | 1 | FIFO holds no words |
| boot_mode | input | 1 | Selects the boot meaning of status bit 9 |
| starve_evt | input | 1 | Host starvation timeout pulse |
| rd_timeout_evt | input | 1 | Data read timeout pulse |
| boot_start_evt | input | 1 | Boot data start pulse |
| xfer_done_evt | input | 1 | Transfer done pulse |
| stat_clr_wr | input | 1 | Write-1-to-clear strobe for status |
| stat_clr_data | input | 16 | Bits to clear |
| irq_en_wr | input | 1 | Interrupt enable register write strobe |
| irq_en_data | input | 16 | New interrupt enable value |
| status | output | 16 | Latched status bits |
| irq | output | 1 | Level interrupt |

## Verification
The bench fills the FIFO to its limit from both sides and then pushes or pops one more time. A design that let a rejected host access move a pointer would return words out of order or report a wrong count. A design that blamed the card side would raise bit 11 where none is due. The bench fires the read timeout in both modes: a design that ignored the mode would raise bit 9 during boot, and one that missed the coupling would leave bit 3 clear. It also lines up a clear and a set on the same bit in one cycle, and it moves the enable register while status is held, to catch clear-over-set priority and an enable that leaks into the status bits.

// File: rtl/sdh_fifo_pkg.sv
package sdh_fifo_pkg;
  localparam int STAT_W     = 16;
  localparam int FERR_BIT   = 11;  // host overrun/underrun
  localparam int STARVE_BIT = 10;  // host starvation timeout
  localparam int RTO_BIT    = 9;   // read timeout, or boot data start in boot mode
  localparam int DONE_BIT   = 3;   // transfer done

  localparam logic [STAT_W-1:0] STAT_IMPL =
    STAT_W'((1 << FERR_BIT) | (1 << STARVE_BIT) | (1 << RTO_BIT) | (1 << DONE_BIT));

  // Fill level after one cycle of accepted pushes and pops.
  function automatic int unsigned next_level(int unsigned lvl, logic inc, logic dec);
    return lvl + int'(inc) - int'(dec);
  endfunction

  // Write-1-to-clear with set priority.
  function automatic logic [STAT_W-1:0] w1c_update(logic [STAT_W-1:0] cur,
                                                   logic [STAT_W-1:0] setv,
                                                   logic [STAT_W-1:0] clrv);
    return ((cur & ~clrv) | setv) & STAT_IMPL;
  endfunction

  // Wrapping pointer advance for a depth that need not be a power of two.
  function automatic int unsigned ptr_inc(int unsigned p, int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/sdh_data_fifo.sv
module sdh_data_fifo
  import sdh_fifo_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_push,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_pop,
  input  logic          card_push,
  input  logic [DW-1:0] card_wdata,
  input  logic          card_pop,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          host_err
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q;
  logic [DW-1:0] rd_q;

  // Named internal events
  logic          push_req, pop_req, push_ok, pop_ok;
  logic          host_ovr, host_und;
  logic [DW-1:0] wsel;

  assign full     = (count_q == CW'(DEPTH));
  assign empty    = (count_q == '0);
  assign push_req = host_push | card_push;
  assign pop_req  = host_pop  | card_pop;
  assign wsel     = host_push ? host_wdata : card_wdata;
  assign push_ok  = push_req & ~full;
  assign pop_ok   = pop_req  & ~empty;
  assign host_ovr = host_push & full;
  assign host_und = host_pop  & empty;
  assign host_err = host_ovr | host_und;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= wsel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
      rd_q    <= '0;
    end else begin
      if (push_ok) wptr_q <= AW'(ptr_inc(int'(wptr_q), DEPTH));
      if (pop_ok) begin
        rptr_q <= AW'(ptr_inc(int'(rptr_q), DEPTH));
        rd_q   <= mem[rptr_q];
      end
      count_q <= CW'(next_level(int'(count_q), push_ok, pop_ok));
    end
  end

  assign count   = count_q;
  assign rd_data = rd_q;

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));
  // R3
  rej_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_push && full && !host_pop && !card_pop) |=> (count_q == $past(count_q)));
  // R4
  rej_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_pop && empty) |=> $stable(rd_q));
  // R5
  card_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_push && !host_pop) |-> !host_err);
endmodule

// File: rtl/sdh_irq_status.sv
module sdh_irq_status
  import sdh_fifo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_mode,
  input  logic              host_err,
  input  logic              starve_evt,
  input  logic              rd_timeout_evt,
  input  logic              boot_start_evt,
  input  logic              xfer_done_evt,
  input  logic              clr_wr,
  input  logic [STAT_W-1:0] clr_data,
  input  logic              en_wr,
  input  logic [STAT_W-1:0] en_data,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  logic [STAT_W-1:0] status_q, en_q;
  logic [STAT_W-1:0] set_vec, clr_vec;

  // Named set events
  logic set_ferr, set_starve, set_rto, set_done;

  assign set_ferr   = host_err;
  assign set_starve = starve_evt;
  assign set_rto    = boot_mode ? boot_start_evt : rd_timeout_evt;
  assign set_done   = xfer_done_evt | (~boot_mode & rd_timeout_evt);

  always_comb begin
    set_vec             = '0;
    set_vec[FERR_BIT]   = set_ferr;
    set_vec[STARVE_BIT] = set_starve;
    set_vec[RTO_BIT]    = set_rto;
    set_vec[DONE_BIT]   = set_done;
  end

  assign clr_vec = clr_wr ? clr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      en_q     <= '0;
    end else begin
      status_q <= w1c_update(status_q, set_vec, clr_vec);
      if (en_wr) en_q <= en_data;
    end
  end

  assign status = status_q;
  assign irq    = |(status_q & en_q);

  // R3 R4
  ferr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_err |=> status_q[FERR_BIT]);
  // R7
  rto_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_mode && rd_timeout_evt) |=> (status_q[RTO_BIT] && status_q[DONE_BIT]));
  // R9
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_data[FERR_BIT] && !host_err) |=> !status_q[FERR_BIT]);
  // R9
  w0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[STARVE_BIT] && !(clr_wr && clr_data[STARVE_BIT])) |=> status_q[STARVE_BIT]);
  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (starve_evt && clr_wr && clr_data[STARVE_BIT]) |=> status_q[STARVE_BIT]);
endmodule

// File: rtl/sdh_fifo_irq.sv
module sdh_fifo_irq
  import sdh_fifo_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_push,
  input  logic [DW-1:0]     host_wdata,
  input  logic              host_pop,
  input  logic              card_push,
  input  logic [DW-1:0]     card_wdata,
  input  logic              card_pop,
  output logic [DW-1:0]     rd_data,
  output logic [CW-1:0]     fifo_count,
  output logic              fifo_full,
  output logic              fifo_empty,
  input  logic              boot_mode,
  input  logic              starve_evt,
  input  logic              rd_timeout_evt,
  input  logic              boot_start_evt,
  input  logic              xfer_done_evt,
  input  logic              stat_clr_wr,
  input  logic [STAT_W-1:0] stat_clr_data,
  input  logic              irq_en_wr,
  input  logic [STAT_W-1:0] irq_en_data,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  logic host_err;

  sdh_data_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_push  (host_push),
    .host_wdata (host_wdata),
    .host_pop   (host_pop),
    .card_push  (card_push),
    .card_wdata (card_wdata),
    .card_pop   (card_pop),
    .rd_data    (rd_data),
    .count      (fifo_count),
    .full       (fifo_full),
    .empty      (fifo_empty),
    .host_err   (host_err)
  );

  sdh_irq_status u_stat (
    .clk            (clk),
    .rst_n          (rst_n),
    .boot_mode      (boot_mode),
    .host_err       (host_err),
    .starve_evt     (starve_evt),
    .rd_timeout_evt (rd_timeout_evt),
    .boot_start_evt (boot_start_evt),
    .xfer_done_evt  (xfer_done_evt),
    .clr_wr         (stat_clr_wr),
    .clr_data       (stat_clr_data),
    .en_wr          (irq_en_wr),
    .en_data        (irq_en_data),
    .status         (status),
    .irq            (irq)
  );

  // R2
  flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));
endmodule

// File: tb/tb_sdh_fifo_irq.sv
`timescale 1ns/1ps
module tb_sdh_fifo_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_push = 0, host_pop = 0, card_push = 0, card_pop = 0;
  logic [31:0] host_wdata = '0, card_wdata = '0;
  logic [31:0] rd_data;
  logic [4:0]  fifo_count;
  logic        fifo_full, fifo_empty;
  logic        boot_mode = 0, starve_evt = 0, rd_timeout_evt = 0;
  logic        boot_start_evt = 0, xfer_done_evt = 0;
  logic        stat_clr_wr = 0, irq_en_wr = 0;
  logic [15:0] stat_clr_data = '0, irq_en_data = '0;
  logic [15:0] status;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  localparam logic [15:0] B11 = 16'h0800;
  localparam logic [15:0] B10 = 16'h0400;
  localparam logic [15:0] B9  = 16'h0200;
  localparam logic [15:0] B3  = 16'h0008;

  always #5 clk = ~clk;

  sdh_fifo_irq dut (
    .clk(clk), .rst_n(rst_n),
    .host_push(host_push), .host_wdata(host_wdata), .host_pop(host_pop),
    .card_push(card_push), .card_wdata(card_wdata), .card_pop(card_pop),
    .rd_data(rd_data), .fifo_count(fifo_count), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .boot_mode(boot_mode), .starve_evt(starve_evt),
    .rd_timeout_evt(rd_timeout_evt), .boot_start_evt(boot_start_evt),
    .xfer_done_evt(xfer_done_evt), .stat_clr_wr(stat_clr_wr),
    .stat_clr_data(stat_clr_data), .irq_en_wr(irq_en_wr),
    .irq_en_data(irq_en_data), .status(status), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    host_push = 0; host_pop = 0; card_push = 0; card_pop = 0;
    starve_evt = 0; rd_timeout_evt = 0; boot_start_evt = 0; xfer_done_evt = 0;
    stat_clr_wr = 0; stat_clr_data = '0; irq_en_wr = 0; irq_en_data = '0;
  endtask

  task automatic clr_all();
    stat_clr_wr = 1; stat_clr_data = 16'hFFFF; tick(); idle();
  endtask

  task automatic t_reset();
    chk("R12 count", 32'(fifo_count), 0);
    chk("R12 empty", 32'(fifo_empty), 1);
    chk("R12 full", 32'(fifo_full), 0);
    chk("R12 rd_data", rd_data, 0);
    chk("R12 status", 32'(status), 0);
    chk("R12 irq", 32'(irq), 0);
  endtask

  task automatic t_fill_drain();
    for (int i = 0; i < 16; i++) begin
      host_push = 1; host_wdata = 32'hA000_0000 + 32'(i * 7); tick();
    end
    idle();
    chk("R2 count full", 32'(fifo_count), 16);
    chk("R2 full flag", 32'(fifo_full), 1);
    for (int i = 0; i < 16; i++) begin
      card_pop = 1; tick();
      chk("R1 order", rd_data, 32'hA000_0000 + 32'(i * 7));
    end
    idle();
    chk("R2 empty flag", 32'(fifo_empty), 1);
    chk("R5 no error on normal traffic", 32'(status), 0);
  endtask

  task automatic t_over_under();
    for (int i = 0; i < 16; i++) begin
      card_push = 1; card_wdata = 32'h5500_0000 + 32'(i); tick();
    end
    card_wdata = 32'hDEAD_0001; tick(); idle();
    chk("R5 card push at full ignored, count", 32'(fifo_count), 16);
    chk("R5 card push at full, no error", 32'(status), 0);
    host_push = 1; host_wdata = 32'hDEAD_0002; tick(); idle();
    chk("R3 overrun sets bit 11", 32'(status), 32'(B11));
    chk("R3 count unchanged", 32'(fifo_count), 16);
    clr_all();
    for (int i = 0; i < 16; i++) begin
      host_pop = 1; tick();
      chk("R3 contents intact", rd_data, 32'h5500_0000 + 32'(i));
    end
    chk("R3 no error from valid pops", 32'(status), 0);
    tick(); idle();
    chk("R4 underrun sets bit 11", 32'(status), 32'(B11));
    chk("R4 rd_data held", rd_data, 32'h5500_000F);
    chk("R4 count held", 32'(fifo_count), 0);
    clr_all();
    host_push = 1; host_wdata = 32'h1234_5678; tick(); idle();
    host_pop = 1; tick(); idle();
    chk("R4 read position not moved", rd_data, 32'h1234_5678);
    card_pop = 1; tick(); idle();
    chk("R5 card pop at empty, no error", 32'(status), 0);
    chk("R5 card pop at empty, rd_data held", rd_data, 32'h1234_5678);
  endtask

  task automatic t_events();
    starve_evt = 1; tick(); idle();
    chk("R6 starvation bit 10", 32'(status), 32'(B10));
    clr_all();
    boot_mode = 0; rd_timeout_evt = 1; tick(); idle();
    chk("R7 read timeout sets 9 and 3", 32'(status), 32'(B9 | B3));
    clr_all();
    xfer_done_evt = 1; tick(); idle();
    chk("R7 done alone", 32'(status), 32'(B3));
    clr_all();
    boot_start_evt = 1; tick(); idle();
    chk("R8 boot start ignored in normal mode", 32'(status), 0);
    boot_mode = 1; rd_timeout_evt = 1; tick(); idle();
    chk("R8 read timeout ignored in boot mode", 32'(status), 0);
    boot_start_evt = 1; tick(); idle();
    chk("R8 boot start sets bit 9", 32'(status), 32'(B9));
    boot_mode = 0;
    clr_all();
  endtask

  task automatic t_w1c();
    starve_evt = 1; rd_timeout_evt = 1; host_pop = 1; tick(); idle();
    chk("R9 setup", 32'(status), 32'(B11 | B10 | B9 | B3));
    stat_clr_wr = 1; stat_clr_data = 16'h0000; tick(); idle();
    chk("R9 write zero holds", 32'(status), 32'(B11 | B10 | B9 | B3));
    stat_clr_wr = 1; stat_clr_data = B10 | B3; tick(); idle();
    chk("R9 selective clear", 32'(status), 32'(B11 | B9));
    clr_all();
    chk("R9 clear all", 32'(status), 0);
  endtask

  task automatic t_set_wins();
    starve_evt = 1; tick(); idle();
    starve_evt = 1; stat_clr_wr = 1; stat_clr_data = B10; tick(); idle();
    chk("R10 set beats clear", 32'(status), 32'(B10));
    clr_all();
    xfer_done_evt = 1; stat_clr_wr = 1; stat_clr_data = B3; tick(); idle();
    chk("R10 set beats clear from zero", 32'(status), 32'(B3));
    clr_all();
  endtask

  task automatic t_irq();
    irq_en_wr = 1; irq_en_data = B10; tick(); idle();
    host_pop = 1; tick(); idle();
    chk("R11 masked bit no irq", 32'(irq), 0);
    chk("R11 status unaffected by enable", 32'(status), 32'(B11));
    starve_evt = 1; tick(); idle();
    chk("R11 enabled bit raises irq", 32'(irq), 1);
    irq_en_wr = 1; irq_en_data = 16'h0000; tick(); idle();
    chk("R11 disable drops irq", 32'(irq), 0);
    chk("R11 disable keeps status", 32'(status), 32'(B11 | B10));
    irq_en_wr = 1; irq_en_data = B11; tick(); idle();
    chk("R11 re-enable other bit", 32'(irq), 1);
    stat_clr_wr = 1; stat_clr_data = B11; tick(); idle();
    chk("R11 clear drops irq", 32'(irq), 0);
    clr_all();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    t_reset();
    t_fill_drain();
    t_over_under();
    t_events();
    t_w1c();
    t_set_wins();
    t_irq();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule